// File: doc/BRIEF.md
# DMA Burst Register Access Window

This block gives a DMA engine an indirect path into a peripheral's register file. The engine does not need a changing address sequence. It reads or writes one fixed window address over and over, and the block sends each access to a different internal register. A burst setup register holds two 5-bit fields: a starting slot and a transfer count. An internal index walks from zero up to the count field. Each window access lands on slot `start + index`, which is byte address `4 * (start + index)`.

The index moves forward on every window read or write. After the last transfer of a burst it drops back to zero, so the next access starts a new burst. Writing the setup register also clears the index. Ordinary accesses to any other address reach their register directly and leave the index alone.

A register file of 32 slots of 16 bits stands in for the peripheral. Slots 18 and 19 are taken by the setup register and the window, so they hold no storage.

Top module: `burst_win_top`

## Requirements
- R1: After reset, the setup register reads 0, the index is 0, every storage slot reads 0, and `rdata_o` is 0.
- R2: The setup register is at byte address 0x48 (slot 18). Bits 12:8 hold the count field and bits 4:0 hold the start field. Every other bit is ignored on write and reads as zero.
- R3: A window access, at byte address 0x4C (slot 19), reads or writes slot `start + index`. The sum is formed without truncation, so it can reach 62.
- R4: The index rises by one after each window access. After the access whose index equals the count field, it returns to 0. The count field therefore encodes transfers minus one, and a field of 0 keeps every access on slot `start`.
- R5: A write to the setup register sets the index to 0.
- R6: A target slot of 32 or above, or slot 18 or 19, reads as zero and drops writes. The index still advances.
- R7: Accesses to any address other than slot 19 leave the index unchanged. Direct reads and writes to storage slots 0–17 and 20–31 reach that slot.
- R8: Read data appears on `rdata_o` one clock after `rd_en_i` and holds until the next read. A write takes effect on the same edge that advances the index. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |

## Verification
The bench goes after four corner cases.

- **Wrap point.** Bursts are run with count fields of 0, 2 and 3. A design with an off-by-one wrap would repeat a slot or skip one.
- **Clear on setup write.** The setup register is rewritten in the middle of a burst. A design that did not clear the index would resume at a later slot.
- **Out-of-range targets.** Start values near the top of the map push targets past slot 31 and onto the two unbacked slots. A truncated sum would alias back onto low slots, and a missing guard would return stale data.
- **Direct accesses mid-burst.** Direct accesses are mixed into bursts. An index that moved on them would shift every later window transfer.

// File: rtl/burst_win_pkg.sv
package burst_win_pkg;
  localparam int FIELD_W   = 5;
  localparam int CTRL_SLOT = 18;
  localparam int WIN_SLOT  = 19;

  typedef struct packed {
    logic [FIELD_W-1:0] cnt;
    logic [FIELD_W-1:0] start;
  } burst_cfg_t;

  function automatic logic [15:0] cfg_word(burst_cfg_t c);
    return {3'b000, c.cnt, 3'b000, c.start};
  endfunction
endpackage

// File: rtl/burst_win_ctrl.sv
module burst_win_ctrl
  import burst_win_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               win_acc_i,
  output burst_cfg_t         cfg_o,
  output logic [FIELD_W-1:0] idx_o
);
  burst_cfg_t         cfg_q;
  logic [FIELD_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      idx_q <= '0;
    end else if (cfg_we_i) begin
      cfg_q.cnt   <= wdata_i[8 +: FIELD_W];
      cfg_q.start <= wdata_i[0 +: FIELD_W];
      idx_q       <= '0;
    end else if (win_acc_i) begin
      // last transfer of the burst wraps to the first
      idx_q <= (idx_q == cfg_q.cnt) ? '0 : idx_q + 1'b1;
    end
  end

  assign cfg_o = cfg_q;
  assign idx_o = idx_q;

  AST_IDX_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= cfg_q.cnt); // R4
  AST_CFG_WR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> idx_q == '0); // R5
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_acc_i && !cfg_we_i && idx_q != cfg_q.cnt) |=> idx_q == $past(idx_q) + 1'b1); // R4
  AST_IDX_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_acc_i && !cfg_we_i && idx_q == cfg_q.cnt) |=> idx_q == '0); // R4
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_acc_i && !cfg_we_i) |=> $stable(idx_q)); // R7
endmodule

// File: rtl/burst_win_bank.sv
module burst_win_bank #(
  parameter int DATA_W    = 16,
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_W    = 6,
  parameter int HOLE_LO   = 18,
  parameter int HOLE_HI   = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IDX_W = $clog2(NUM_SLOTS);

  logic [DATA_W-1:0] regs [NUM_SLOTS];
  logic              in_range;

  assign in_range = slot_i < SLOT_W'(NUM_SLOTS);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    if (g >= HOLE_LO && g <= HOLE_HI) begin : g_hole
      assign regs[g] = '0;
    end else begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                               q <= '0;
        else if (we_i && slot_i == SLOT_W'(g))     q <= wdata_i;
      end
      assign regs[g] = q;
    end
  end

  assign rdata_o = in_range ? regs[slot_i[IDX_W-1:0]] : '0;

  AST_OOR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_range |-> rdata_o == '0); // R6
endmodule

// File: rtl/burst_win_top.sv
module burst_win_top
  import burst_win_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int NUM_SLOTS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int SLOT_W = ADDR_W - 2;

  logic [SLOT_W-1:0]  slot, target, acc_slot;
  logic               is_cfg, is_win, win_acc;
  burst_cfg_t         cfg;
  logic [FIELD_W-1:0] idx;
  logic [DATA_W-1:0]  bank_rd, rd_mux, rdata_q;

  assign slot     = addr_i[ADDR_W-1:2];
  assign is_cfg   = slot == SLOT_W'(CTRL_SLOT);
  assign is_win   = slot == SLOT_W'(WIN_SLOT);
  assign win_acc  = is_win && (wr_en_i || rd_en_i);
  assign target   = SLOT_W'(cfg.start) + SLOT_W'(idx);
  assign acc_slot = is_win ? target : slot;

  burst_win_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_we_i  (wr_en_i && is_cfg),
    .wdata_i   (wdata_i),
    .win_acc_i (win_acc),
    .cfg_o     (cfg),
    .idx_o     (idx)
  );

  burst_win_bank #(
    .DATA_W    (DATA_W),
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W),
    .HOLE_LO   (CTRL_SLOT),
    .HOLE_HI   (WIN_SLOT)
  ) bank_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i && !is_cfg),
    .slot_i  (acc_slot),
    .wdata_i (wdata_i),
    .rdata_o (bank_rd)
  );

  assign rd_mux = is_cfg ? DATA_W'(cfg_word(cfg)) : bank_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  AST_CFG_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && is_cfg) |=> (rdata_o & 16'hE0E0) == '0); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R8
endmodule

// File: tb/burst_win_tb.sv
`timescale 1ns/1ps
module burst_win_top_tb_top;
  localparam int SEED = 32'h5eed;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] m_mem [32];
  int m_cnt, m_start, m_idx;

  always #2.5 clk = ~clk;

  burst_win_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic bit m_valid(int s);
    return s < 32 && s != 18 && s != 19;
  endfunction

  // model of one access; returns expected read data
  task automatic m_access(input int s, input bit we, input logic [15:0] wd,
                          output logic [15:0] exp_rd);
    int t;
    if (s == 18) begin
      exp_rd = 16'((m_cnt << 8) | m_start);
      if (we) begin m_cnt = int'(wd[12:8]); m_start = int'(wd[4:0]); m_idx = 0; end
    end else if (s == 19) begin
      t = m_start + m_idx;
      exp_rd = m_valid(t) ? m_mem[t] : 16'h0;
      if (we && m_valid(t)) m_mem[t] = wd;
      m_idx = (m_idx == m_cnt) ? 0 : m_idx + 1;
    end else begin
      exp_rd = m_valid(s) ? m_mem[s] : 16'h0;
      if (we && m_valid(s)) m_mem[s] = wd;
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic acc(input int s, input bit we, input bit re,
                     input logic [15:0] wd, input string tag);
    logic [15:0] exp_rd;
    m_access(s, we, wd, exp_rd);
    addr  = 8'((s << 2) | ($urandom & 3));
    wr_en = we; rd_en = re; wdata = wd;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (re) begin
      n_chk++;
      if (rdata !== exp_rd) begin
        n_fail++;
        $display("FAIL %s slot %0d: got %h expected %h", tag, s, rdata, exp_rd);
      end
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(SEED));
    for (int i = 0; i < 32; i++) m_mem[i] = '0;
    m_cnt = 0; m_start = 0; m_idx = 0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (rdata !== 16'h0) begin n_fail++; $display("FAIL R1 rdata %h expected 0000", rdata); end
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    acc(18, 0, 1, 0, "R1");
    acc(19, 0, 1, 0, "R1");
    acc(5, 0, 1, 0, "R1");
    acc(40, 0, 1, 0, "R1");
    // R2 field positions, reserved bits read zero
    acc(18, 1, 0, 16'hFFFF, "R2");
    acc(18, 0, 1, 0, "R2");
    for (int i = 0; i < 8; i++) acc(i, 1, 0, 16'hA000 + 16'(i), "R7");
    // R3 / R4 count field 2, start 1: slots 1,2,3,1
    acc(18, 1, 0, 16'h0201, "R2");
    for (int i = 0; i < 5; i++) acc(19, 0, 1, 0, "R4");
    // R4 single-transfer burst
    acc(18, 1, 0, 16'h0004, "R4");
    acc(19, 0, 1, 0, "R4");
    acc(19, 0, 1, 0, "R4");
    // R5 clear mid-burst
    acc(18, 1, 0, 16'h0300, "R5");
    acc(19, 0, 1, 0, "R5");
    acc(19, 0, 1, 0, "R5");
    acc(18, 1, 0, 16'h0300, "R5");
    acc(19, 0, 1, 0, "R5");
    // R7 direct accesses mid-burst leave index alone
    acc(6, 0, 1, 0, "R7");
    acc(7, 1, 0, 16'h1234, "R7");
    acc(19, 0, 1, 0, "R7");
    // R3 / R8 window write then back-to-back read
    acc(19, 1, 0, 16'hBEEF, "R3");
    acc(2, 0, 1, 0, "R8");
    acc(3, 0, 1, 0, "R8");
    // R6 targets past slot 31
    acc(18, 1, 0, 16'h031E, "R6");
    for (int i = 0; i < 4; i++) acc(19, 1, 0, 16'h5500 + 16'(i), "R6");
    for (int i = 0; i < 5; i++) acc(19, 0, 1, 0, "R6");
    acc(0, 0, 1, 0, "R6");
    acc(1, 0, 1, 0, "R6");
    // R6 targets on unbacked slots 18, 19
    acc(18, 1, 0, 16'h0211, "R6");
    for (int i = 0; i < 3; i++) acc(19, 1, 0, 16'h7700, "R6");
    for (int i = 0; i < 3; i++) acc(19, 0, 1, 0, "R6");
    acc(18, 0, 1, 0, "R6");
    // random mix
    for (int i = 0; i < 2000; i++) begin
      int op = int'($urandom % 8);
      case (op)
        0: acc(18, 1, 0, 16'($urandom), "R2");
        1, 2, 3: acc(19, 0, 1, 0, "R4");
        4: acc(19, 1, 0, 16'($urandom), "R3");
        5: acc(int'($urandom % 64), 0, 1, 0, "R7");
        6: acc(int'($urandom % 18), 1, 0, 16'($urandom), "R7");
        default: acc(20 + int'($urandom % 12), 1, 1, 16'($urandom), "R8");
      endcase
    end
    summary();
  end
endmodule